// File: doc/BRIEF.md
# Half to Single Precision Converter

This block widens a 16-bit binary floating-point value into a 32-bit single-precision value. It takes a 32-bit source word and a select that chooses which 16-bit half is converted. Every representable half value maps exactly onto a single-precision value, so the block has no rounding stage. It registers the result one cycle after a qualified input.

It handles four kinds of input. Zeros keep their sign. Subnormal halves are renormalized into normal singles using a leading-zero count, so the whole conversion fits in one cycle. Normal values are rebiased. The top exponent code is treated in one of two ways. In the standard format it means infinity or NaN: signalling NaNs are quieted and raise a sticky invalid flag, and an optional default-NaN control replaces every NaN with the canonical quiet NaN. In the alternative format that code is an ordinary normal exponent.

Top module: `h2s_convert`

## Requirements
- R1: When `pick_upper` is 1 the operand is `src_word[31:16]`; when it is 0 the operand is `src_word[15:0]`. The other half has no effect on the result.
- R2: An operand with bits 14:0 all zero gives a signed zero: the result is bit 15 of the operand followed by 31 zero bits.
- R3: An operand with exponent field (bits 14:10) zero and a nonzero fraction (bits 9:0) gives a normal single. The fraction is shifted left until its leading one leaves the 10-bit field. The single exponent is 113 minus the shift count. The shifted fraction fills result bits 22:13, and bits 12:0 are zero.
- R4: An operand with exponent 1..30 gives result exponent (bits 30:23) equal to the half exponent plus 112. The fraction goes to bits 22:13, and the sign is copied to bit 31.
- R5: In the standard format (`alt_fmt`=0), exponent 31 with a zero fraction gives a signed infinity: exponent 0xFF and fraction 0.
- R6: In the standard format, exponent 31 with a nonzero fraction gives a NaN. The result has exponent 0xFF, the half fraction in bits 22:13, bit 22 forced to 1, and the sign kept. If operand bit 9 is 0, the value is signalling and `inv_sticky` is set.
- R7: With `dflt_nan`=1 in the standard format, every NaN result is 0x7FC00000. A signalling operand still sets `inv_sticky`.
- R8: With `alt_fmt`=1, exponent 31 is converted like any normal exponent (result exponent 143), and no input sets `inv_sticky`.
- R9: `inv_sticky` stays at 1 once set, until reset. Reset clears the result and `inv_sticky` to zero.
- R10: A conversion launched with `cvt_en`=1 appears on `sgl_out` after the next rising clock edge. While `cvt_en` is 0, `sgl_out` and `inv_sticky` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cvt_en | input | 1 | Convert the presented operand at this edge |
| src_word | input | 32 | Word holding two half-precision values |
| pick_upper | input | 1 | 1 selects bits 31:16, 0 selects bits 15:0 |
| dflt_nan | input | 1 | Replace NaN results with the canonical quiet NaN |
| alt_fmt | input | 1 | Alternative format: exponent 31 is a normal exponent |
| sgl_out | output | 32 | Registered single-precision result |
| inv_sticky | output | 1 | Sticky invalid-operation flag |

## Verification
The block has little internal state: a result register and one sticky flag. A wrong leading-zero count or a wrong exponent offset shows up on `sgl_out` in the cycle after the offending operand. The bench therefore sweeps all 65536 half encodings in the standard format, alternating the half select. It then repeats the top-exponent region with default-NaN and with the alternative format. A flag that sets wrongly or fails to hold shows up at the first signalling NaN, at code 0x7C01, and stays visible on every later comparison.

// File: rtl/h2s_pkg.sv
package h2s_pkg;
  localparam int HEXP_W   = 5;
  localparam int HFRAC_W  = 10;
  localparam int HALF_W   = 1 + HEXP_W + HFRAC_W;
  localparam int SEXP_W   = 8;
  localparam int SFRAC_W  = 23;
  localparam int SGL_W    = 1 + SEXP_W + SFRAC_W;
  localparam int WORD_W   = 2 * HALF_W;
  localparam int FRAC_PAD = SFRAC_W - HFRAC_W;
  localparam int HBIAS    = (1 << (HEXP_W - 1)) - 1;
  localparam int SBIAS    = (1 << (SEXP_W - 1)) - 1;
  localparam int BIAS_ADJ = SBIAS - HBIAS;
  localparam int LZ_W     = $clog2(HFRAC_W + 1);

  typedef struct packed {
    logic               sign;
    logic [HEXP_W-1:0]  exp;
    logic [HFRAC_W-1:0] frac;
  } half_t;

  typedef struct packed {
    logic               sign;
    logic [SEXP_W-1:0]  exp;
    logic [SFRAC_W-1:0] frac;
  } sgl_t;
endpackage

// File: rtl/h2s_pick.sv
module h2s_pick
  import h2s_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              upper_i,
  output half_t             half_o
);
  always_comb begin
    if (upper_i) half_o = half_t'(word_i[WORD_W-1:HALF_W]);
    else         half_o = half_t'(word_i[HALF_W-1:0]);
  end
endmodule

// File: rtl/h2s_lzc.sv
module h2s_lzc #(
  parameter int W   = 10,
  parameter int CNT = $clog2(W + 1)
) (
  input  logic [W-1:0]   vec_i,
  output logic [CNT-1:0] cnt_o
);
  logic [W:0] seen;
  logic [CNT-1:0] pos_cnt [W+1];

  assign seen[W]    = 1'b0;
  assign pos_cnt[W] = CNT'(W);

  for (genvar i = W - 1; i >= 0; i--) begin : g_scan
    assign seen[i]    = seen[i+1] | vec_i[i];
    assign pos_cnt[i] = (vec_i[i] && !seen[i+1]) ? CNT'(W - 1 - i) : pos_cnt[i+1];
  end

  assign cnt_o = pos_cnt[0];
endmodule

// File: rtl/h2s_core.sv
module h2s_core
  import h2s_pkg::*;
(
  input  half_t               half_i,
  input  logic                dflt_nan_i,
  input  logic                alt_fmt_i,
  output logic [SGL_W-1:0]    res_o,
  output logic                snan_o
);
  localparam logic [HEXP_W-1:0] HEXP_TOP = '1;
  localparam logic [SEXP_W-1:0] SEXP_TOP = '1;
  localparam logic [SEXP_W-1:0] ADJ      = SEXP_W'(BIAS_ADJ);

  logic [LZ_W-1:0]    lz;
  logic [HFRAC_W:0]   norm_frac;
  logic               exp_zero;
  logic               frac_zero;
  logic               top_code;
  sgl_t               res;

  h2s_lzc #(.W(HFRAC_W), .CNT(LZ_W)) u_lzc (
    .vec_i (half_i.frac),
    .cnt_o (lz)
  );

  assign exp_zero  = (half_i.exp == '0);
  assign frac_zero = (half_i.frac == '0);
  assign top_code  = (half_i.exp == HEXP_TOP) && !alt_fmt_i;
  assign norm_frac = {1'b0, half_i.frac} << (lz + LZ_W'(1));

  always_comb begin
    res.sign = half_i.sign;
    res.exp  = {{(SEXP_W-HEXP_W){1'b0}}, half_i.exp} + ADJ;
    res.frac = {half_i.frac, {FRAC_PAD{1'b0}}};
    snan_o   = 1'b0;
    if (exp_zero) begin
      if (frac_zero) begin
        res.exp  = '0;
        res.frac = '0;
      end else begin
        res.exp  = ADJ - {{(SEXP_W-LZ_W){1'b0}}, lz};
        res.frac = {norm_frac[HFRAC_W-1:0], {FRAC_PAD{1'b0}}};
      end
    end else if (top_code) begin
      res.exp = SEXP_TOP;
      if (frac_zero) begin
        res.frac = '0;
      end else begin
        snan_o = !half_i.frac[HFRAC_W-1];
        res.frac[SFRAC_W-1] = 1'b1;
        if (dflt_nan_i) begin
          res.sign = 1'b0;
          res.frac[SFRAC_W-2:0] = '0;
        end
      end
    end
  end

  assign res_o = res;
endmodule

// File: rtl/h2s_convert.sv
module h2s_convert
  import h2s_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cvt_en,
  input  logic [WORD_W-1:0] src_word,
  input  logic              pick_upper,
  input  logic              dflt_nan,
  input  logic              alt_fmt,
  output logic [SGL_W-1:0]  sgl_out,
  output logic              inv_sticky
);
  half_t            op;
  logic [SGL_W-1:0] core_res;
  logic             core_snan;
  logic [SGL_W-1:0] res_q, res_d;
  logic             inv_q, inv_d;

  h2s_pick u_pick (
    .word_i  (src_word),
    .upper_i (pick_upper),
    .half_o  (op)
  );

  h2s_core u_core (
    .half_i     (op),
    .dflt_nan_i (dflt_nan),
    .alt_fmt_i  (alt_fmt),
    .res_o      (core_res),
    .snan_o     (core_snan)
  );

  always_comb begin
    res_d = res_q;
    inv_d = inv_q;
    if (cvt_en) begin
      res_d = core_res;
      inv_d = inv_q | core_snan;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      inv_q <= 1'b0;
    end else begin
      res_q <= res_d;
      inv_q <= inv_d;
    end
  end

  assign sgl_out    = res_q;
  assign inv_sticky = inv_q;
endmodule

// File: rtl/h2s_convert_chk.sv
module h2s_convert_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cvt_en,
  input logic [31:0] src_word,
  input logic        pick_upper,
  input logic        dflt_nan,
  input logic        alt_fmt,
  input logic [31:0] sgl_out,
  input logic        inv_sticky
);
  logic [15:0] hsel;
  logic        is_nan_code;
  assign hsel        = pick_upper ? src_word[31:16] : src_word[15:0];
  assign is_nan_code = (hsel[14:10] == 5'h1F) && (hsel[9:0] != 10'd0) && !alt_fmt;

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cvt_en |=> ($stable(sgl_out) && $stable(inv_sticky)));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_sticky |=> inv_sticky);

  assert_alt_noinv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cvt_en && alt_fmt && !inv_sticky) |=> !inv_sticky);

  assert_signed_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cvt_en && hsel[14:0] == 15'd0) |=> (sgl_out == {$past(hsel[15]), 31'd0}));

  assert_default_nan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cvt_en && dflt_nan && is_nan_code) |=> (sgl_out == 32'h7FC0_0000));

  assert_snan_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cvt_en && is_nan_code && !hsel[9]) |=> inv_sticky);
endmodule

bind h2s_convert h2s_convert_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cvt_en     (cvt_en),
  .src_word   (src_word),
  .pick_upper (pick_upper),
  .dflt_nan   (dflt_nan),
  .alt_fmt    (alt_fmt),
  .sgl_out    (sgl_out),
  .inv_sticky (inv_sticky)
);

// File: tb/sim_h2s_convert.sv
`timescale 1ns/1ps
module sim_h2s_convert;
  logic        clk;
  logic        rst_n;
  logic        cvt_en;
  logic [31:0] src_word;
  logic        pick_upper;
  logic        dflt_nan;
  logic        alt_fmt;
  logic [31:0] sgl_out;
  logic        inv_sticky;

  int checks = 0;
  int errors = 0;
  bit exp_inv = 1'b0;
  bit done = 1'b0;

  h2s_convert u0 (
    .clk(clk), .rst_n(rst_n), .cvt_en(cvt_en), .src_word(src_word),
    .pick_upper(pick_upper), .dflt_nan(dflt_nan), .alt_fmt(alt_fmt),
    .sgl_out(sgl_out), .inv_sticky(inv_sticky)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Expected single value, from the requirement text
  function automatic logic [31:0] model(input logic [15:0] h, input bit dn,
                                        input bit alt, output bit sig);
    logic       s;
    int         e, m, mm, ee;
    logic [22:0] f;
    s = h[15]; e = int'(h[14:10]); m = int'(h[9:0]); sig = 1'b0;
    if (e == 0 && m == 0) return {s, 31'd0};
    if (e == 0) begin
      mm = m; ee = 113;
      while (mm < 1024) begin mm = mm * 2; ee = ee - 1; end
      return {s, 8'(ee), 10'(mm), 13'd0};
    end
    if (e == 31 && !alt) begin
      if (m == 0) return {s, 8'hFF, 23'd0};
      sig = (h[9] == 1'b0);
      f = {h[9:0], 13'd0};
      f[22] = 1'b1;
      if (dn) begin f = 23'h40_0000; s = 1'b0; end
      return {s, 8'hFF, f};
    end
    return {s, 8'(e + 112), h[9:0], 13'd0};
  endfunction

  function automatic string tag_of(input logic [15:0] h, input bit dn, input bit alt);
    if (h[14:10] == 5'd31 && alt) return "R8";
    if (h[14:10] == 5'd31 && h[9:0] != 0 && dn) return "R7";
    if (h[14:10] == 5'd31 && h[9:0] != 0) return "R6";
    if (h[14:10] == 5'd31) return "R5";
    if (h[14:0] == 0) return "R2";
    if (h[14:10] == 0) return "R3";
    return "R4";
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cvt_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_inv = 1'b0;
  endtask

  // Drive one operand, check it after the next rising edge (R10 latency)
  task automatic convert(input logic [15:0] h, input bit top, input bit dn, input bit alt);
    logic [31:0] e;
    bit sig;
    @(negedge clk);
    cvt_en     = 1'b1;
    pick_upper = top;
    dflt_nan   = dn;
    alt_fmt    = alt;
    // R1: unselected half carries unrelated bits
    src_word   = top ? {h, ~h} : {h ^ 16'hA5C3, h};
    e = model(h, dn, alt, sig);
    if (sig && !alt) exp_inv = 1'b1;
    @(posedge clk);
    #1;
    check32({tag_of(h, dn, alt), top ? "/R1 upper" : "/R1 lower"}, sgl_out, e);
    check32("R9 sticky invalid", {31'd0, inv_sticky}, {31'd0, exp_inv});
    cvt_en = 1'b0;
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    src_word = '0; pick_upper = 1'b0; dflt_nan = 1'b0; alt_fmt = 1'b0;
    do_reset();
    @(negedge clk);
    check32("R9 reset result", sgl_out, 32'd0);
    check32("R9 reset invalid", {31'd0, inv_sticky}, 32'd0);

    // Full sweep, standard format, alternating half select (R1..R6, R9)
    for (int i = 0; i < 65536; i++) convert(16'(i), i[0], 1'b0, 1'b0);

    // R10: hold while enable is low, with a changing word
    held = sgl_out;
    @(negedge clk);
    src_word = 32'h3C00_3C00; pick_upper = 1'b1;
    repeat (3) @(negedge clk);
    check32("R10 hold result", sgl_out, held);
    check32("R10 hold invalid", {31'd0, inv_sticky}, 32'd1);

    // R8: alternative format over the top exponent region and some neighbours
    do_reset();
    for (int i = 0; i < 2048; i++) begin
      convert({i[10], 5'h1F, 10'(i)}, i[1], i[2], 1'b1);
    end
    convert(16'h7C01, 1'b0, 1'b0, 1'b1);
    check32("R8 alt no invalid", {31'd0, inv_sticky}, 32'd0);

    // R7: default NaN over the top exponent region
    do_reset();
    for (int i = 0; i < 2048; i++) begin
      convert({i[10], 5'h1F, 10'(i)}, i[0], 1'b1, 1'b0);
    end

    // Spot values of the R3 boundary
    convert(16'h0001, 1'b1, 1'b0, 1'b0);
    check32("R3 smallest subnormal", sgl_out, 32'h3380_0000);
    convert(16'h83FF, 1'b0, 1'b0, 1'b0);
    check32("R3 largest negative subnormal", sgl_out, 32'hB87F_C000);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule